// File: doc/BRIEF.md
# SPI Slave Transmitter with Filler-Byte Insertion

This block is the transmit side of an SPI slave running in mode 0 (SCK idles low, the master samples on the rising edge, MISO moves on the falling edge, most significant bit first). A local producer pushes bytes into a small FIFO. The serializer sends them on MISO while the slave-select input is held low. The SCK and slave-select inputs must already be synchronous to the block clock. Both are sampled and edge-detected inside the block.

Once a session is running and at least one full byte has been clocked in, the block guards the producer against a late start. When a byte is written into an empty FIFO, one filler byte is queued ahead of it, as though the producer had written that byte first. The filler is either 0xFF or a copy of the byte sent just before it, chosen by a configuration input. When the serializer needs a byte and neither data nor a queued filler is available, it sends the filler value and sets a sticky underrun flag.

The controller has three states:
- ST_DESEL: waiting for select.
- ST_LOAD: one cycle in which a byte is chosen and placed in the shifter.
- ST_SHIFT: counting SCK edges.

Its transitions are:
- ST_DESEL to ST_LOAD on the select falling edge.
- ST_LOAD to ST_SHIFT on the next cycle.
- ST_SHIFT to ST_LOAD on the eighth rising SCK edge.
- ST_LOAD or ST_SHIFT to ST_DESEL whenever select is high.

Top module: `spi_pad_tx`

## Requirements
- R1: After reset, tx_free=1, tx_idle=1, underrun=0, rx_byte_done=0 and miso=0.
- R2: On each byte boundary and at the start of a session, a byte is placed in the shifter before the next rising SCK edge. Its bit 7 appears on miso first, and each falling SCK edge after a rising one shifts the next lower bit out. miso is 0 while deselected.
- R3: The FIFO holds 4 bytes and sends them in write order. A write while the FIFO is full is dropped.
- R4: tx_free is 0 exactly while the FIFO is full. It returns to 1 once a byte is moved from the FIFO into the shifter.
- R5: tx_idle is 1 only when the FIFO is empty, no filler is queued and no FIFO or queued-filler byte is still in the shifter.
- R6: rx_byte_done pulses for one cycle after every eighth rising SCK edge of a selected session. A partial byte gives no pulse.
- R7: Filler insertion is armed after the first rx_byte_done of a session and disarmed when ss_n goes high. Before arming, a write into an empty FIFO queues no filler.
- R8: While armed, a write into an empty FIFO queues exactly one filler byte, which is sent before the written byte and raises no underrun.
- R9: The filler value is 0xFF when pad_rpt=0. When pad_rpt=1 it is the byte sent on miso just before it, with 0xFF used if no byte has been sent since reset.
- R10: When a byte must be loaded with the FIFO empty and no filler queued, the filler value is sent and underrun is set. underrun stays 1 until a pulse on err_clr. A new underrun in the same cycle takes priority over the clear.
- R11: Raising ss_n resets the bit count, so the next session starts on a byte boundary. The FIFO contents are kept across the deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push wr_data into the transmit FIFO |
| wr_data | input | 8 | Byte to transmit |
| pad_rpt | input | 1 | Filler select: 0 gives 0xFF, 1 repeats the previous byte |
| err_clr | input | 1 | Clears the underrun flag |
| sck | input | 1 | SPI clock from the master, synchronous to clk |
| ss_n | input | 1 | Active-low slave select, synchronous to clk |
| miso | output | 1 | Serial data to the master |
| rx_byte_done | output | 1 | One-cycle strobe per completed byte |
| tx_free | output | 1 | FIFO has room for a write |
| tx_idle | output | 1 | Nothing left to send |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The following are checked on every cycle:
- underrun stays set until it is cleared.
- A rise of underrun only follows a load from an empty FIFO.
- A full FIFO stays full when a write arrives without a pop.
- rx_byte_done never lasts two cycles.
- tx_idle implies tx_free.
- miso stays low while deselected.

The byte values seen by the master can only be shown by the directed scenarios. These cover:
- write order;
- where the filler appears and what value it takes;
- that no filler is queued before arming or after a deselect;
- realignment after a partial byte;
- that a dropped write never appears.

// File: rtl/spi_pad_pkg.sv
package spi_pad_pkg;
    typedef enum logic [1:0] {
        ST_DESEL,
        ST_LOAD,
        ST_SHIFT
    } tx_state_t;

    localparam logic [7:0] FILL_ONES = 8'hFF;
endpackage

// File: rtl/spi_pad_fifo.sv
module spi_pad_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/spi_pad_edges.sv
module spi_pad_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ss_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_start
);
    logic sck_q, ss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            ss_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            ss_q  <= ss_n;
        end
    end

    assign sck_rise  = sck && !sck_q;
    assign sck_fall  = !sck && sck_q;
    assign sel_start = ss_q && !ss_n;
endmodule

// File: rtl/spi_pad_ctrl.sv
module spi_pad_ctrl
    import spi_pad_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ss_n,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         sel_start,
    input  logic         wr_en,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    input  logic         pad_rpt,
    input  logic         err_clr,
    output logic         fifo_pop,
    output logic         miso,
    output logic         rx_byte_done,
    output logic         underrun,
    output logic         busy,
    output logic         pad_pending
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    tx_state_t     state, state_nx;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  shreg, last_byte, fill_val;
    logic          armed, pad_due, last_bit;

    assign fill_val = pad_rpt ? last_byte : W'(FILL_ONES);
    assign pad_due  = pad_pending || (armed && wr_en && fifo_empty);
    assign last_bit = (bit_cnt == CW'(W - 1));

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DESEL: if (sel_start) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ss_n ? ST_DESEL : ST_SHIFT;
            ST_SHIFT: begin
                if (ss_n)                      state_nx = ST_DESEL;
                else if (sck_rise && last_bit) state_nx = ST_LOAD;
            end
            default:  state_nx = ST_DESEL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DESEL;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        fifo_pop = (state == ST_LOAD) && !ss_n && !pad_due && !fifo_empty;
        miso     = (state != ST_DESEL) && shreg[W-1];
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            last_byte    <= W'(FILL_ONES);
            armed        <= 1'b0;
            pad_pending  <= 1'b0;
            busy         <= 1'b0;
            rx_byte_done <= 1'b0;
            underrun     <= 1'b0;
        end else begin
            rx_byte_done <= 1'b0;
            if (err_clr) underrun <= 1'b0;
            if (armed && wr_en && fifo_empty) pad_pending <= 1'b1;

            if (ss_n) begin
                bit_cnt     <= '0;
                armed       <= 1'b0;
                pad_pending <= 1'b0;
                busy        <= 1'b0;
            end else if (state == ST_LOAD) begin
                bit_cnt <= '0;
                if (pad_due) begin
                    shreg       <= fill_val;
                    last_byte   <= fill_val;
                    busy        <= 1'b1;
                    pad_pending <= 1'b0;
                end else if (!fifo_empty) begin
                    shreg     <= fifo_head;
                    last_byte <= fifo_head;
                    busy      <= 1'b1;
                end else begin
                    shreg     <= fill_val;
                    last_byte <= fill_val;
                    busy      <= 1'b0;
                    underrun  <= 1'b1;
                end
            end else if (state == ST_SHIFT) begin
                if (sck_rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) begin
                        rx_byte_done <= 1'b1;
                        armed        <= 1'b1;
                    end
                end else if (sck_fall && bit_cnt != '0) begin
                    shreg <= {shreg[W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_pad_tx.sv
module spi_pad_tx #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pad_rpt,
    input  logic         err_clr,
    input  logic         sck,
    input  logic         ss_n,
    output logic         miso,
    output logic         rx_byte_done,
    output logic         tx_free,
    output logic         tx_idle,
    output logic         underrun
);
    logic         sck_rise, sck_fall, sel_start;
    logic         fifo_pop, fifo_empty, fifo_full;
    logic [W-1:0] fifo_head;
    logic         busy, pad_pending;

    spi_pad_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .ss_n      (ss_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sel_start (sel_start)
    );

    spi_pad_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    spi_pad_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ss_n         (ss_n),
        .sck_rise     (sck_rise),
        .sck_fall     (sck_fall),
        .sel_start    (sel_start),
        .wr_en        (wr_en),
        .fifo_empty   (fifo_empty),
        .fifo_head    (fifo_head),
        .pad_rpt      (pad_rpt),
        .err_clr      (err_clr),
        .fifo_pop     (fifo_pop),
        .miso         (miso),
        .rx_byte_done (rx_byte_done),
        .underrun     (underrun),
        .busy         (busy),
        .pad_pending  (pad_pending)
    );

    assign tx_free = !fifo_full;
    assign tx_idle = fifo_empty && !pad_pending && !busy;
endmodule

// File: rtl/spi_pad_tx_chk.sv
module spi_pad_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic err_clr,
    input logic ss_n,
    input logic miso,
    input logic rx_byte_done,
    input logic tx_free,
    input logic tx_idle,
    input logic underrun,
    input logic fifo_empty,
    input logic fifo_full,
    input logic fifo_pop
);
    p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !err_clr |=> underrun);

    p_err_from_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(fifo_empty));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && wr_en && !fifo_pop |=> fifo_full);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_done |=> !rx_byte_done);

    p_idle_has_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_free);

    p_quiet_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n && $past(ss_n) |-> !miso);
endmodule

bind spi_pad_tx spi_pad_tx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .err_clr      (err_clr),
    .ss_n         (ss_n),
    .miso         (miso),
    .rx_byte_done (rx_byte_done),
    .tx_free      (tx_free),
    .tx_idle      (tx_idle),
    .underrun     (underrun),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .fifo_pop     (fifo_pop)
);

// File: tb/spi_pad_tx_test.sv
`timescale 1ns/1ps
module spi_pad_tx_test;
    localparam int HALF  = 4;
    localparam int LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pad_rpt = 1'b0;
    logic       err_clr = 1'b0;
    logic       sck = 1'b0;
    logic       ss_n = 1'b1;
    logic       miso, rx_byte_done, tx_free, tx_idle, underrun;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int rx_cnt = 0;

    spi_pad_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pad_rpt(pad_rpt), .err_clr(err_clr), .sck(sck), .ss_n(ss_n),
        .miso(miso), .rx_byte_done(rx_byte_done), .tx_free(tx_free),
        .tx_idle(tx_idle), .underrun(underrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rx_byte_done) rx_cnt <= rx_cnt + 1;
        if (cycles > LIMIT) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic select();
        @(negedge clk); ss_n = 1'b0;
    endtask

    task automatic deselect();
        @(negedge clk); ss_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic xfer(input int nbits, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            repeat (HALF) @(negedge clk);
            b = {b[6:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 tx_free", 8'(tx_free), 8'h01);
        check("R1 tx_idle", 8'(tx_idle), 8'h01);
        check("R1 underrun", 8'(underrun), 8'h00);
        check("R1 miso", 8'(miso), 8'h00);
        check("R1 rx_byte_done", 8'(rx_byte_done), 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] b;
        int n0;
        pad_rpt = 1'b0;
        push(8'hA5); push(8'h3C);
        check("R5 idle low with data", 8'(tx_idle), 8'h00);
        n0 = rx_cnt;
        select();
        xfer(8, b); check("R2 first byte msb first", b, 8'hA5);
        xfer(8, b); check("R3 second byte order", b, 8'h3C);
        check("R10 underrun on empty load", 8'(underrun), 8'h01);
        check("R5 idle after last byte", 8'(tx_idle), 8'h01);
        xfer(8, b); check("R9 filler ones", b, 8'hFF);
        check("R10 underrun sticky", 8'(underrun), 8'h01);
        check("R6 strobe count", 8'(rx_cnt - n0), 8'd3);
        clear_err();
        check("R10 err_clr", 8'(underrun), 8'h00);
        deselect();
    endtask

    task automatic t_full();
        logic [7:0] b;
        pad_rpt = 1'b0;
        for (int i = 1; i <= 4; i++) push(8'(i));
        check("R4 free low when full", 8'(tx_free), 8'h00);
        push(8'h05);
        select();
        repeat (3) @(negedge clk);
        check("R4 free after pop", 8'(tx_free), 8'h01);
        for (int i = 1; i <= 4; i++) begin
            xfer(8, b); check("R3 fifo order", b, 8'(i));
        end
        xfer(8, b); check("R3 dropped write absent", b, 8'hFF);
        deselect();
        clear_err();
    endtask

    task automatic t_pad();
        logic [7:0] b;
        pad_rpt = 1'b1;
        push(8'h12);
        select();
        repeat (3) @(negedge clk);
        push(8'h34);
        xfer(8, b); check("R2 byte1", b, 8'h12);
        push(8'h56);
        check("R5 idle low with filler queued", 8'(tx_idle), 8'h00);
        xfer(8, b); check("R7 no filler before arming", b, 8'h34);
        xfer(8, b); check("R8 filler repeats previous", b, 8'h34);
        check("R8 no underrun from filler", 8'(underrun), 8'h00);
        xfer(8, b); check("R8 data after filler", b, 8'h56);
        check("R10 underrun after drain", 8'(underrun), 8'h01);
        check("R5 idle after drain", 8'(tx_idle), 8'h01);
        xfer(8, b); check("R9 underrun filler repeats", b, 8'h56);
        deselect();
        clear_err();
    endtask

    task automatic t_desel();
        logic [7:0] b;
        int n0;
        pad_rpt = 1'b0;
        push(8'hAA); push(8'hBB);
        n0 = rx_cnt;
        select();
        xfer(4, b); check("R2 partial nibble", b, 8'h0A);
        deselect();
        check("R6 no strobe on partial", 8'(rx_cnt - n0), 8'd0);
        check("R11 fifo kept (idle low)", 8'(tx_idle), 8'h00);
        check("R2 miso low deselected", 8'(miso), 8'h00);
        select();
        xfer(8, b); check("R11 realigned byte", b, 8'hBB);
        deselect();
        clear_err();
        push(8'h99);
        select();
        xfer(8, b); check("R7 disarmed after deselect", b, 8'h99);
        deselect();
        clear_err();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_full();
        t_pad();
        t_desel();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule